// File: doc/BRIEF.md
# Timer Channel Count and Status Snapshot Controller

This block sits in front of a bank of three timer channels. It decodes byte writes to a shared control register and serves byte reads from each channel's count port. The counting engines are not part of the block. Each channel supplies its live 16-bit count, its output level, its null-count flag, its programmed mode and its access mode as plain inputs.

Two control words make the block take snapshots. The single-channel count freeze names one channel and captures only its count. The multi-channel snapshot command can capture the count, the status byte, or both, for any subset of the three channels in one write. A snapshot stays frozen until software has read all of its bytes. While a snapshot is pending, further snapshot commands for the same channel and the same item are ignored. Count bytes come out one byte per read, in the order set by the channel's access mode. This lets software read a 16-bit value that stays consistent across two byte reads.

Top module: `timer_latch_ctrl`

## Requirements
- R1: After synchronous reset, no snapshot is held, `rd_valid` and `rd_data` are 0, and every channel's next count read returns the low byte.
- R2: A control write with bits 7:6 = 00, 01 or 10 (channel 0, 1 or 2) and bits 5:4 = 00 freezes that channel's count only. Later count reads return the frozen value even when the live count changes.
- R3: A control write with bits 7:6 = 11 is a snapshot command. Bits 1, 2 and 3 select channels 0, 1 and 2. Bit 5 = 0 captures the count and bit 4 = 0 captures the status. Any subset of channels is captured in one write.
- R4: A snapshot command with bit 0 = 1 has no effect.
- R5: The status byte is {bit 7 output level, bit 6 null-count flag, bits 5:4 access mode, bits 3:1 mode, bit 0 BCD select}.
- R6: When both status and count are held, the first read returns the status byte and the following reads return the count bytes.
- R7: Byte order follows the access mode. 01 returns the low byte only, 10 returns the high byte only, and 11 or 00 returns the low byte and then the high byte. A held count is released after its final byte is read.
- R8: A repeat command for a count or status that is still held is ignored. Count and status are held and released independently.
- R9: With nothing held, reads return the live count bytes in the same order.
- R10: `rd_data` and `rd_valid` are registered and appear one cycle after `rd_en`. A read of a channel index at or above the channel count returns 0 and changes no state.
- R11: Other control words (bits 7:6 not 11 and bits 5:4 not 00) capture nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control-register write strobe |
| wr_data | input | 8 | Control word |
| rd_en | input | 1 | Count-port read strobe |
| rd_sel | input | 2 | Channel index being read |
| live_count | input | 48 | Live counts, channel i at bits 16i+15:16i |
| chan_out | input | 3 | Output level per channel |
| chan_null | input | 3 | Null-count flag per channel |
| chan_mode | input | 9 | Programmed mode, 3 bits per channel |
| chan_bcd | input | 3 | BCD select per channel |
| chan_rw | input | 6 | Access mode, 2 bits per channel |
| rd_data | output | 8 | Returned byte |
| rd_valid | output | 1 | High the cycle after a read |

## Verification
The hardest situation to reach is a channel that holds a partly read count while further commands for it arrive and its live inputs keep changing. In that state a faulty design could overwrite the frozen value or the frozen status without any visible sign. To reach it, the stimulus freezes a count, reads only its low byte, moves the live count to a new value, and then issues the same freeze again. The next byte read must come from the first capture. A separate sequence holds a status byte, flips the channel's output level and snapshots the status again, which shows that the held byte is not replaced. A third sequence holds status and count together and checks that they are released independently.

// File: rtl/timer_latch_pkg.sv
package timer_latch_pkg;
  localparam int BYTE_W = 8;
  localparam int MODE_W = 3;
  localparam int RW_W   = 2;

  localparam logic [1:0] RW_LOW  = 2'b01;
  localparam logic [1:0] RW_HIGH = 2'b10;

  typedef struct packed {
    logic              out_lvl;
    logic              null_cnt;
    logic [RW_W-1:0]   rw;
    logic [MODE_W-1:0] mode;
    logic              bcd;
  } status_t;

  function automatic logic [BYTE_W-1:0] pack_status(
    input logic out_lvl, input logic null_cnt,
    input logic [RW_W-1:0] rw, input logic [MODE_W-1:0] mode,
    input logic bcd);
    status_t s;
    s.out_lvl  = out_lvl;
    s.null_cnt = null_cnt;
    s.rw       = rw;
    s.mode     = mode;
    s.bcd      = bcd;
    return s;
  endfunction
endpackage

// File: rtl/timer_cmd_decode.sv
module timer_cmd_decode #(
  parameter int NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic [NUM_CH-1:0] cnt_req,
  output logic [NUM_CH-1:0] sts_req
);
  logic is_snap;
  assign is_snap = wr_en && (wr_data[7:6] == 2'b11) && !wr_data[0];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
    localparam logic [1:0] CH_ID = 2'(i);
    logic single_hit;
    assign single_hit = wr_en && (wr_data[7:6] == CH_ID) && (wr_data[5:4] == 2'b00);
    assign cnt_req[i] = single_hit || (is_snap && wr_data[i+1] && !wr_data[5]);
    assign sts_req[i] = is_snap && wr_data[i+1] && !wr_data[4];
  end

  // R4: a snapshot word with bit 0 set must raise no request
  assert_rsv_bit_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[7:6] == 2'b11 && wr_data[0]) |-> (cnt_req == '0 && sts_req == '0));
  // R2: a single-channel freeze touches at most one count and no status
  assert_single_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[7:6] != 2'b11) |-> ($onehot0(cnt_req) && sts_req == '0));
endmodule

// File: rtl/timer_chan_latch.sv
module timer_chan_latch
  import timer_latch_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_req,
  input  logic              sts_req,
  input  logic              rd_hit,
  input  logic [CNT_W-1:0]  live_cnt,
  input  logic [BYTE_W-1:0] sts_in,
  input  logic [RW_W-1:0]   rw_mode,
  output logic [BYTE_W-1:0] byte_out
);
  logic             cnt_held, sts_held, hi_next;
  logic [CNT_W-1:0] cnt_q;
  logic [BYTE_W-1:0] sts_q;

  logic             two_byte, last_byte;
  logic [CNT_W-1:0] src;
  logic [BYTE_W-1:0] lo_b, hi_b, cnt_byte;

  assign two_byte  = (rw_mode != RW_LOW) && (rw_mode != RW_HIGH);
  assign last_byte = !two_byte || hi_next;
  assign src       = cnt_held ? cnt_q : live_cnt;
  assign lo_b      = src[BYTE_W-1:0];
  assign hi_b      = src[CNT_W-1 -: BYTE_W];

  always_comb begin
    if (two_byte)                cnt_byte = hi_next ? hi_b : lo_b;
    else if (rw_mode == RW_HIGH) cnt_byte = hi_b;
    else                         cnt_byte = lo_b;
    byte_out = sts_held ? sts_q : cnt_byte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_held <= 1'b0;
      sts_held <= 1'b0;
      hi_next  <= 1'b0;
      cnt_q    <= '0;
      sts_q    <= '0;
    end else begin
      if (rd_hit) begin
        if (sts_held) begin
          sts_held <= 1'b0;
        end else begin
          if (two_byte) hi_next <= !hi_next;
          if (cnt_held && last_byte) cnt_held <= 1'b0;
        end
      end
      if (cnt_req && !cnt_held) begin
        cnt_held <= 1'b1;
        cnt_q    <= live_cnt;
        hi_next  <= 1'b0;
      end
      if (sts_req && !sts_held) begin
        sts_held <= 1'b1;
        sts_q    <= sts_in;
      end
    end
  end

  // R8: a held count stays frozen until a read can release it
  assert_cnt_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    (cnt_held && !rd_hit) |=> (cnt_held && $stable(cnt_q)));
  // R8: a held status stays frozen until it is read
  assert_sts_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    (sts_held && !rd_hit) |=> (sts_held && $stable(sts_q)));
  // R2: a fresh capture takes the live count of the command cycle
  assert_cnt_capture_R2: assert property (@(posedge clk) disable iff (rst)
    (cnt_req && !cnt_held) |=> (cnt_held && cnt_q == $past(live_cnt)));
  // R6: reading a held status releases it and leaves the count untouched
  assert_sts_release_R6: assert property (@(posedge clk) disable iff (rst)
    (sts_held && rd_hit && !sts_req) |=> (!sts_held && $stable(cnt_q)));
endmodule

// File: rtl/timer_rd_port.sv
module timer_rd_port
  import timer_latch_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int SEL_W  = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          rd_en,
  input  logic [SEL_W-1:0]              rd_sel,
  input  logic [NUM_CH-1:0][BYTE_W-1:0] ch_bytes,
  output logic [NUM_CH-1:0]             rd_hit,
  output logic [BYTE_W-1:0]             rd_data,
  output logic                          rd_valid
);
  logic [BYTE_W-1:0] pick;

  always_comb begin
    pick   = '0;
    rd_hit = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (rd_sel == SEL_W'(i)) begin
        pick      = ch_bytes[i];
        rd_hit[i] = rd_en;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= pick;
    end
  end

  // R10: every read returns a byte in the following cycle
  assert_rd_latency_R10: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
  assert_rd_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);
  // R10: an index past the last channel reads as zero and strobes nothing
  assert_rd_oob_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_sel >= SEL_W'(NUM_CH)) |=> (rd_data == '0));
endmodule

// File: rtl/timer_latch_ctrl.sv
module timer_latch_ctrl
  import timer_latch_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 16,
  localparam int SEL_W = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [7:0]               wr_data,
  input  logic                     rd_en,
  input  logic [SEL_W-1:0]         rd_sel,
  input  logic [NUM_CH*CNT_W-1:0]  live_count,
  input  logic [NUM_CH-1:0]        chan_out,
  input  logic [NUM_CH-1:0]        chan_null,
  input  logic [NUM_CH*MODE_W-1:0] chan_mode,
  input  logic [NUM_CH-1:0]        chan_bcd,
  input  logic [NUM_CH*RW_W-1:0]   chan_rw,
  output logic [BYTE_W-1:0]        rd_data,
  output logic                     rd_valid
);
  logic [NUM_CH-1:0]             cnt_req, sts_req, rd_hit;
  logic [NUM_CH-1:0][BYTE_W-1:0] ch_bytes;

  timer_cmd_decode #(.NUM_CH(NUM_CH)) u_dec (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .cnt_req(cnt_req), .sts_req(sts_req)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic [BYTE_W-1:0] sts_byte;
    assign sts_byte = pack_status(chan_out[i], chan_null[i],
                                  chan_rw[i*RW_W +: RW_W],
                                  chan_mode[i*MODE_W +: MODE_W], chan_bcd[i]);
    timer_chan_latch #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst(rst),
      .cnt_req(cnt_req[i]), .sts_req(sts_req[i]), .rd_hit(rd_hit[i]),
      .live_cnt(live_count[i*CNT_W +: CNT_W]),
      .sts_in(sts_byte), .rw_mode(chan_rw[i*RW_W +: RW_W]),
      .byte_out(ch_bytes[i])
    );
  end

  timer_rd_port #(.NUM_CH(NUM_CH), .SEL_W(SEL_W)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_sel(rd_sel),
    .ch_bytes(ch_bytes), .rd_hit(rd_hit),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );
endmodule

// File: tb/timer_latch_ctrl_bench.sv
module timer_latch_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_sel = '0;
  logic [47:0] live_count = {16'h0F0E, 16'hABCD, 16'h1234};
  logic [2:0]  chan_out  = 3'b101;
  logic [2:0]  chan_null = 3'b010;
  logic [8:0]  chan_mode = {3'd4, 3'd3, 3'd2};
  logic [2:0]  chan_bcd  = 3'b001;
  logic [5:0]  chan_rw   = {2'b10, 2'b01, 2'b11};
  logic [7:0]  rd_data;
  logic        rd_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  timer_latch_ctrl u_timer_latch_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_sel(rd_sel), .live_count(live_count),
    .chan_out(chan_out), .chan_null(chan_null), .chan_mode(chan_mode),
    .chan_bcd(chan_bcd), .chan_rw(chan_rw),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  // vector: {op[1:0] 0=write 1=read 2=set live, sel[1:0], data[15:0], exp[7:0], req[3:0]}
  localparam int NV = 46;
  localparam logic [31:0] VEC [NV] = '{
    {2'd0, 2'd0, 16'h0000, 8'h00, 4'd2},  // R2 freeze ch0 count (1234)
    {2'd2, 2'd0, 16'h5555, 8'h00, 4'd2},
    {2'd0, 2'd0, 16'h0000, 8'h00, 4'd8},  // R8 repeat ignored
    {2'd1, 2'd0, 16'h0000, 8'h34, 4'd2},  // R2 frozen low byte
    {2'd2, 2'd0, 16'h6666, 8'h00, 4'd8},
    {2'd0, 2'd0, 16'h0000, 8'h00, 4'd8},  // R8 repeat between bytes
    {2'd1, 2'd0, 16'h0000, 8'h12, 4'd7},  // R7 high byte, release
    {2'd1, 2'd0, 16'h0000, 8'h66, 4'd9},  // R9 live low
    {2'd1, 2'd0, 16'h0000, 8'h66, 4'd9},  // R9 live high
    {2'd0, 2'd0, 16'h00C2, 8'h00, 4'd3},  // R3 snapshot ch0 count+status
    {2'd2, 2'd0, 16'h7777, 8'h00, 4'd6},
    {2'd1, 2'd0, 16'h0000, 8'hB5, 4'd5},  // R5 R6 status first
    {2'd1, 2'd0, 16'h0000, 8'h66, 4'd6},  // R6 then count low
    {2'd1, 2'd0, 16'h0000, 8'h66, 4'd6},  // R6 count high
    {2'd1, 2'd0, 16'h0000, 8'h77, 4'd7},  // R7 released, live
    {2'd1, 2'd0, 16'h0000, 8'h77, 4'd7},
    {2'd0, 2'd0, 16'h00DE, 8'h00, 4'd3},  // R3 all three counts
    {2'd2, 2'd0, 16'h0000, 8'h00, 4'd3},
    {2'd2, 2'd1, 16'h0000, 8'h00, 4'd3},
    {2'd2, 2'd2, 16'h0000, 8'h00, 4'd3},
    {2'd1, 2'd1, 16'h0000, 8'hCD, 4'd7},  // R7 low-only access
    {2'd1, 2'd1, 16'h0000, 8'h00, 4'd7},  // R7 released after one byte
    {2'd1, 2'd2, 16'h0000, 8'h0F, 4'd7},  // R7 high-only access
    {2'd1, 2'd2, 16'h0000, 8'h00, 4'd7},
    {2'd1, 2'd0, 16'h0000, 8'h77, 4'd3},  // R3 ch0 captured too
    {2'd1, 2'd0, 16'h0000, 8'h77, 4'd3},
    {2'd1, 2'd0, 16'h0000, 8'h00, 4'd9},
    {2'd1, 2'd0, 16'h0000, 8'h00, 4'd9},
    {2'd0, 2'd0, 16'h00EC, 8'h00, 4'd3},  // R3 status only ch1, ch2
    {2'd1, 2'd1, 16'h0000, 8'h56, 4'd5},  // R5 ch1 status
    {2'd1, 2'd2, 16'h0000, 8'hA8, 4'd5},  // R5 ch2 status
    {2'd1, 2'd1, 16'h0000, 8'h00, 4'd3},  // R3 no count was held
    {2'd1, 2'd2, 16'h0000, 8'h00, 4'd3},
    {2'd2, 2'd1, 16'h1122, 8'h00, 4'd4},
    {2'd0, 2'd0, 16'h00C5, 8'h00, 4'd4},  // R4 bit0 set, ignored
    {2'd1, 2'd1, 16'h0000, 8'h22, 4'd4},
    {2'd0, 2'd0, 16'h0070, 8'h00, 4'd11}, // R11 mode write
    {2'd2, 2'd1, 16'h3344, 8'h00, 4'd11},
    {2'd1, 2'd1, 16'h0000, 8'h44, 4'd11},
    {2'd1, 2'd3, 16'h0000, 8'h00, 4'd10}, // R10 index out of range
    {2'd0, 2'd0, 16'h00E4, 8'h00, 4'd8},  // R8 status ch1 held
    {2'd2, 2'd1, 16'h5A5A, 8'h00, 4'd8},
    {2'd0, 2'd0, 16'h0040, 8'h00, 4'd8},  // R8 count ch1 independent
    {2'd2, 2'd1, 16'h0000, 8'h00, 4'd8},
    {2'd1, 2'd1, 16'h0000, 8'h56, 4'd6},  // R6 status before count
    {2'd1, 2'd1, 16'h0000, 8'h5A, 4'd8}   // R8 count kept while status held
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_rd(input logic [1:0] s, input logic [7:0] exp, input string req);
    @(negedge clk);
    rd_en = 1'b1; rd_sel = s;
    @(negedge clk);
    rd_en = 1'b0;
    check(req, {7'd0, rd_valid}, 8'd1);
    check(req, rd_data, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 rd_valid", {7'd0, rd_valid}, 8'd0);
    check("R1 rd_data", rd_data, 8'd0);

    for (int v = 0; v < NV; v++) begin
      logic [1:0] op, sel;
      logic [15:0] dat;
      logic [7:0] exp;
      string tag;
      {op, sel, dat, exp} = VEC[v][31:4];
      tag = $sformatf("R%0d vector %0d", VEC[v][3:0], v);
      case (op)
        2'd0: do_wr(dat[7:0]);
        2'd1: do_rd(sel, exp, tag);
        default: begin
          @(negedge clk);
          live_count[sel*16 +: 16] = dat;
        end
      endcase
    end

    // R8: held status is not replaced by a second snapshot
    do_rd(2'd1, 8'h00, "R9 drain ch1");
    do_wr(8'hE4);
    chan_out[1] = 1'b1;
    do_wr(8'hE4);
    do_rd(2'd1, 8'h56, "R8 status kept");
    do_rd(2'd1, 8'h00, "R9 after status");
    do_wr(8'hE4);
    do_rd(2'd1, 8'hD6, "R5 fresh status");
    chan_out[1] = 1'b0;

    // R1: reset drops a pending freeze and the byte pointer
    live_count[15:0] = 16'h1357;
    do_wr(8'h00);
    do_rd(2'd0, 8'h57, "R2 low before reset");
    live_count[15:0] = 16'h2468;
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 rd_valid after reset", {7'd0, rd_valid}, 8'd0);
    check("R1 rd_data after reset", rd_data, 8'd0);
    do_rd(2'd0, 8'h68, "R1 live low after reset");
    do_rd(2'd0, 8'h24, "R1 live high after reset");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule